// File: doc/BRIEF.md
# Three-Level Sigma-Delta Bridge Modulator

This block turns a stream of signed, already filtered audio samples into the two gate-drive bits of a bridge-tied load. Each drive bit selects ground or the supply for one side of the load. The difference between the two sides therefore takes one of three values: positive, zero or negative. A first-order error-feedback loop quantises each sample to one of these three levels. When the input is silent, both sides stay low and no current is pushed into the load. As the signal level rises, differential pulses become more frequent.

Samples arrive on a valid/ready stream. Each accepted sample is applied to the loop for a fixed number of modulator clocks, set by the `HOLD` parameter. During that time the block refuses new samples. A transfer takes place on any rising clock edge that sees both `in_valid` and `in_ready` high. `in_ready` is high while no sample has yet been loaded, and in the last cycle of each hold period. If no new sample arrives when a hold period ends, the current sample is repeated and `in_ready` stays high. Data offered while `in_ready` is low is not taken.

Mute and enable act at once. A half-pulse mode lets each pulse last only the high phase of the modulator clock, which saves switching energy.

Top module: `tlsd_modulator`

## Requirements
- R1: A positive level drives `out_p`=1 and `out_n`=0. A negative level drives `out_p`=0 and `out_n`=1. The zero level drives both outputs low. The two outputs are never high together.
- R2: A stream of zero samples produces no pulse on either output.
- R3: The loop adds the held sample to an integrator. If the sum is at least FS/2, the level is positive and FS is subtracted. If the sum is at most −FS/2, the level is negative and FS is added. Otherwise the level is zero. FS is 2^(DATA_W−1). A constant input x therefore yields pulses of the sign of x on a fraction |x|/FS of the cycles.
- R4: A held input of −FS gives a negative pulse on every modulator cycle.
- R5: `enable` low or `mute` high, sampled at a rising edge, forces both outputs low from that edge on and clears the integrator. After release with an input of FS/4, the outputs over the next six edges follow the pattern zero, positive, zero, zero, zero, positive.
- R6: With `half_mode` high, an active pulse is removed at the falling clock edge, so it is seen only in the high phase. With `half_mode` low, a pulse lasts the whole cycle.
- R7: `in_ready` is high when no sample is loaded, and in the last of the `HOLD` cycles of a hold period. After a transfer it is low for `HOLD`−1 cycles. Data offered while it is low is ignored.
- R8: When no new sample is offered, the last accepted sample keeps being applied.
- R9: During reset, both outputs are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the modulator |
| mute | input | 1 | Force silence and clear the loop |
| half_mode | input | 1 | Shorten pulses to the clock high phase |
| in_valid | input | 1 | Sample stream valid |
| in_ready | output | 1 | Sample stream ready |
| in_data | input | DATA_W | Signed two's-complement sample |
| out_p | output | 1 | Drive for the non-inverting side |
| out_n | output | 1 | Drive for the inverting side |

## Verification
The bench probes the quantiser thresholds with quarter-scale, half-scale and negative full-scale inputs. A wrong comparison or a wrong feedback weight shows up as a pulse count off the expected density, or as pulses of the wrong sign. After a mute and after a disable, it checks the exact six-cycle pulse pattern; a loop whose integrator is not cleared would start from a stale residue and place the first pulse in a different cycle. It samples both clock phases to catch a half-pulse mask that is missing, or inverted onto the high phase. It also offers a sample during a busy hold period; a design that ignored back-pressure would take that sample and emit negative pulses where none belong.

// File: rtl/tlsd_pkg.sv
`timescale 1ns/1ps
package tlsd_pkg;

  // Ternary decision of the quantiser
  typedef enum logic [1:0] {
    LVL_ZERO = 2'b00,
    LVL_POS  = 2'b01,
    LVL_NEG  = 2'b10
  } level_e;

endpackage

// File: rtl/tlsd_sample_hold.sv
`timescale 1ns/1ps
module tlsd_sample_hold #(
  parameter int DATA_W = 16,
  parameter int HOLD   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_data,
  output logic signed [DATA_W-1:0] sample
);

  localparam int CW = (HOLD > 2) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic          loaded_q;
  logic [CW-1:0] cnt_q;
  logic          take;

  assign in_ready = !loaded_q || (cnt_q == LAST);
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
      cnt_q    <= '0;
      sample   <= '0;
    end else if (take) begin
      loaded_q <= 1'b1;
      cnt_q    <= '0;
      sample   <= in_data;
    end else if (loaded_q && cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/tlsd_loop.sv
`timescale 1ns/1ps
module tlsd_loop
  import tlsd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       active,
  input  logic signed [DATA_W-1:0]   sample,
  output level_e                     level,
  output logic signed [DATA_W+1:0]   integ_o
);

  localparam int AW = DATA_W + 2;
  localparam logic signed [AW-1:0] FULL  = AW'(2 ** (DATA_W - 1));
  localparam logic signed [AW-1:0] HALF  = FULL >>> 1;
  localparam logic signed [AW-1:0] NHALF = -HALF;

  logic signed [AW-1:0] integ_q, integ_d, acc;
  level_e               lvl_d;

  always_comb begin
    acc = integ_q + $signed({{2{sample[DATA_W-1]}}, sample});
    if (acc >= HALF) begin
      lvl_d   = LVL_POS;
      integ_d = acc - FULL;
    end else if (acc <= NHALF) begin
      lvl_d   = LVL_NEG;
      integ_d = acc + FULL;
    end else begin
      lvl_d   = LVL_ZERO;
      integ_d = acc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q <= '0;
      level   <= LVL_ZERO;
    end else if (!active) begin
      integ_q <= '0;
      level   <= LVL_ZERO;
    end else begin
      integ_q <= integ_d;
      level   <= lvl_d;
    end
  end

  assign integ_o = integ_q;

endmodule

// File: rtl/tlsd_bridge_drv.sv
`timescale 1ns/1ps
module tlsd_bridge_drv
  import tlsd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   half_mode,
  input  level_e level,
  output logic   out_p,
  output logic   out_n
);

  logic half_q;
  logic tog_rise_q;
  logic tog_fall_q;
  logic mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q     <= 1'b0;
      tog_rise_q <= 1'b0;
    end else begin
      half_q     <= half_mode;
      tog_rise_q <= ~tog_rise_q;
    end
  end

  // Catches up with the rising-edge toggle at each falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) tog_fall_q <= 1'b0;
    else        tog_fall_q <= tog_rise_q;
  end

  // Equal toggles mean the low phase of the clock
  assign mask  = half_q && (tog_rise_q == tog_fall_q);
  assign out_p = (level == LVL_POS) && !mask;
  assign out_n = (level == LVL_NEG) && !mask;

endmodule

// File: rtl/tlsd_modulator.sv
`timescale 1ns/1ps
module tlsd_modulator
  import tlsd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int HOLD   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     mute,
  input  logic                     half_mode,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_p,
  output logic                     out_n
);

  logic signed [DATA_W-1:0] sample;
  logic signed [DATA_W+1:0] integ_mon;
  level_e                   level;
  logic                     active;

  assign active = enable && !mute;

  tlsd_sample_hold #(.DATA_W(DATA_W), .HOLD(HOLD)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .sample   (sample)
  );

  tlsd_loop #(.DATA_W(DATA_W)) u_loop (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (active),
    .sample  (sample),
    .level   (level),
    .integ_o (integ_mon)
  );

  tlsd_bridge_drv u_drv (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_mode (half_mode),
    .level     (level),
    .out_p     (out_p),
    .out_n     (out_n)
  );

endmodule

// File: rtl/tlsd_modulator_chk.sv
`timescale 1ns/1ps
module tlsd_modulator_chk #(
  parameter int DATA_W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     enable,
  input logic                     mute,
  input logic                     half_mode,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic                     out_p,
  input logic                     out_n,
  input logic signed [DATA_W+1:0] integ_mon
);

  p_never_both_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_p && out_n));

  p_silence_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || mute) |=> (!out_p && !out_n));

  p_integ_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || mute) |=> (integ_mon == '0));

  p_busy_after_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_low_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(half_mode)) |-> (!out_p && !out_n));

endmodule

bind tlsd_modulator tlsd_modulator_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .mute      (mute),
  .half_mode (half_mode),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_p     (out_p),
  .out_n     (out_n),
  .integ_mon (integ_mon)
);

// File: tb/tlsd_modulator_test.sv
`timescale 1ns/1ps
module tlsd_modulator_test;

  localparam int W    = 16;
  localparam int HOLD = 4;
  localparam int FS   = 2 ** (W - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, mute = 1'b0, half_mode = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [W-1:0] in_data = '0;
  logic out_p, out_n;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tlsd_modulator #(.DATA_W(W), .HOLD(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mute(mute),
    .half_mode(half_mode), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_p(out_p), .out_n(out_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic after_rise();
    @(posedge clk); #2;
  endtask

  task automatic set_sample(input int v);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = W'(v);
    repeat (HOLD + 3) after_rise();
  endtask

  task automatic window(input int n, output int cp, output int cn);
    cp = 0; cn = 0;
    for (int i = 0; i < n; i++) begin
      after_rise();
      cp += int'(out_p);
      cn += int'(out_n);
      if (out_p && out_n) check(1'b0, "R1 both high", 1, 0);
    end
  endtask

  task automatic t_reset();
    #12;
    check(!out_p && !out_n, "R9 outputs in reset", {out_p, out_n}, 0);
    check(in_ready, "R9 ready in reset", in_ready, 1);
    @(negedge clk); rst_n = 1'b1; enable = 1'b1;
  endtask

  task automatic t_zero();
    int cp, cn;
    set_sample(0);
    window(64, cp, cn);
    check(cp == 0 && cn == 0, "R2 zero input pulses", cp + cn, 0);
  endtask

  task automatic t_density(input int v, input int exp_p, input int exp_n, input string tag);
    int cp, cn;
    set_sample(v);
    window(64, cp, cn);
    check(cp >= exp_p - 1 && cp <= exp_p + 1, {tag, " positive count"}, cp, exp_p);
    check(cn >= exp_n - 1 && cn <= exp_n + 1, {tag, " negative count"}, cn, exp_n);
  endtask

  task automatic t_neg_full();
    int cp, cn;
    set_sample(-FS);
    window(64, cp, cn);
    check(cn == 64 && cp == 0, "R4 full negative every cycle", cn, 64);
  endtask

  // Releases either mute or disable and checks the restart pattern
  task automatic t_silence(input bit use_mute);
    int cp, cn;
    bit exp_p;
    set_sample(FS / 4);
    @(negedge clk);
    if (use_mute) mute = 1'b1; else enable = 1'b0;
    window(6, cp, cn);
    check(cp == 0 && cn == 0, "R5 silenced outputs", cp + cn, 0);
    @(negedge clk);
    if (use_mute) mute = 1'b0; else enable = 1'b1;
    for (int i = 0; i < 6; i++) begin
      after_rise();
      exp_p = (i == 1) || (i == 5);
      check(out_p == exp_p && !out_n, "R5 restart pattern", int'(out_p), int'(exp_p));
    end
  endtask

  task automatic t_half();
    int hi_cnt = 0;
    bit hi;
    set_sample(FS / 2);
    @(negedge clk); half_mode = 1'b1;
    for (int i = 0; i < 16; i++) begin
      after_rise();
      hi = out_p;
      hi_cnt += int'(hi);
      @(negedge clk); #2;
      check(!out_p && !out_n, "R6 low phase cleared", int'(out_p), 0);
    end
    check(hi_cnt >= 7 && hi_cnt <= 9, "R6 high phase pulses", hi_cnt, 8);
    @(negedge clk); half_mode = 1'b0;
    for (int i = 0; i < 16; i++) begin
      after_rise();
      hi = out_p;
      @(negedge clk); #2;
      check(out_p == hi, "R6 full cycle pulse", int'(out_p), int'(hi));
    end
  endtask

  task automatic t_stream();
    int cp, cn;
    @(negedge clk); in_valid = 1'b0;
    repeat (6) after_rise();
    check(in_ready, "R7 idle ready", in_ready, 1);
    @(negedge clk); in_valid = 1'b1; in_data = W'(FS / 2);
    after_rise();
    check(!in_ready, "R7 busy after take 1", in_ready, 0);
    @(negedge clk); in_data = W'(-FS);
    after_rise();
    check(!in_ready, "R7 busy after take 2", in_ready, 0);
    @(negedge clk); in_valid = 1'b0;
    after_rise();
    check(!in_ready, "R7 busy after take 3", in_ready, 0);
    after_rise();
    check(in_ready, "R7 ready at hold end", in_ready, 1);
    window(32, cp, cn);
    check(cn == 0, "R7 refused sample ignored", cn, 0);
    check(cp >= 15 && cp <= 17, "R8 held sample repeats", cp, 16);
  endtask

  initial begin
    t_reset();
    t_zero();
    t_density(FS / 4, 16, 0, "R3 quarter scale R1");
    t_density(FS / 2, 32, 0, "R3 half scale");
    t_density(-FS / 4, 0, 16, "R3 negative quarter R1");
    t_neg_full();
    t_silence(1'b1);
    t_silence(1'b0);
    t_half();
    t_stream();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule